// File: doc/BRIEF.md
# Receiver Error Sample Hold

This block sits after the decoder in the receive path of a digital audio interface. Each decoded sample arrives with a valid strobe and seven error flags. The block decides which sample to forward when an enabled error is present, raises a combined receiver-error event, and keeps a sticky error status word that clears when it is read.

A per-bit enable mask picks which error sources count as errors for the substitution policy and for the event. A two-bit policy field picks the substitute sample. The substitute can be the last clean sample, zero, or the received sample itself. Every flag reported with a valid sample is recorded in the status word, whether or not its mask bit is set.

Top module: `rx_err_hold`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_sample` takes its new value in that same cycle and keeps its value while `in_valid` is low.
- R2: A valid sample with no enabled error is forwarded unchanged. "Enabled error" means some bit of `err_flags & err_mask` is 1.
- R3: With an enabled error and `policy` 2'b00, the output is the last clean sample. The reserved code 2'b11 behaves the same way.
- R4: With an enabled error and `policy` 2'b01, the output is zero.
- R5: With an enabled error and `policy` 2'b10, the received sample is forwarded unchanged.
- R6: An error whose mask bit is 0 does not trigger the policy and does not raise `rx_err`. It is still recorded in `err_status`.
- R7: `rx_err` is high for one cycle, together with `out_valid`, when the sample carried an enabled error.
- R8: The status and mask bit positions are fixed. Bit 6 is the Q-subcode CRC error, bit 5 the channel-status CRC error, bit 4 PLL unlock, bit 3 validity (1 = invalid data), bit 2 confidence, bit 1 bi-phase error and bit 0 parity error. Each flag seen with a valid sample sets its status bit, and the bit stays set until it is read.
- R9: A `status_rd` pulse clears `err_status` on the next cycle. A flag that arrives in the same cycle as the read stays set.
- R10: After reset, `out_valid`, `rx_err`, `out_sample` and `err_status` are zero, and the held sample is zero.
- R11: The held sample is updated only by valid samples that carry no enabled error. A sample forwarded under policy 2'b10 does not replace it.
- R12: While `in_valid` is low, the error flags and the sample have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | W | Decoded audio sample |
| err_flags | input | 7 | Per-sample error flags (bit layout per R8) |
| err_mask | input | 7 | Error enable mask, 1 = enabled |
| policy | input | 2 | Substitution policy on error |
| status_rd | input | 1 | Status read strobe, clears on the next cycle |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | W | Forwarded or substituted sample |
| rx_err | output | 1 | Combined receiver-error event |
| err_status | output | 7 | Sticky error status |

## Verification
Directed sequences first run a clean sample and then the same error under each policy code, including the reserved one. This separates hold, zero and pass from one another. A sequence of clean sample, then an error passed under policy 2'b10, then an error under hold shows whether a passed error sample wrongly replaces the held value. Other cases put masked flags on a sample, time a read in the same cycle as a new flag, and present flags while the strobe is low. Random samples, flags, masks and policies then run against a bench reference model, which covers the interaction of the sticky status with frequent reads.

// File: rtl/rx_err_hold.sv
module rx_err_hold #(
  parameter int W    = 24,
  parameter int NERR = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [W-1:0]    in_sample,
  input  logic [NERR-1:0] err_flags,
  input  logic [NERR-1:0] err_mask,
  input  logic [1:0]      policy,
  input  logic            status_rd,
  output logic            out_valid,
  output logic [W-1:0]    out_sample,
  output logic            rx_err,
  output logic [NERR-1:0] err_status
);
  logic          hit;
  logic [W-1:0]  held_q;
  logic [W-1:0]  subst;

  assign hit = in_valid && |(err_flags & err_mask);

  always_comb begin
    case (policy)
      2'b01:   subst = '0;
      2'b10:   subst = in_sample;
      default: subst = held_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      rx_err     <= 1'b0;
      out_sample <= '0;
      held_q     <= '0;
      err_status <= '0;
    end else begin
      out_valid  <= in_valid;
      rx_err     <= hit;
      if (in_valid) out_sample <= hit ? subst : in_sample;
      if (in_valid && !hit) held_q <= in_sample;
      err_status <= (status_rd ? '0 : err_status) | (in_valid ? err_flags : '0);
    end
  end
endmodule

module rx_err_hold_chk #(
  parameter int W    = 24,
  parameter int NERR = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [W-1:0]    in_sample,
  input logic [NERR-1:0] err_flags,
  input logic [NERR-1:0] err_mask,
  input logic [1:0]      policy,
  input logic            status_rd,
  input logic            out_valid,
  input logic [W-1:0]    out_sample,
  input logic            rx_err,
  input logic [NERR-1:0] err_status
);
  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_clean_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (err_flags & err_mask) == '0) |=> out_sample == $past(in_sample));
  p_zero_policy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (err_flags & err_mask) != '0 && policy == 2'b01) |=> out_sample == '0);
  p_event_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> out_valid);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !status_rd |=> (err_status & $past(err_status)) == $past(err_status));
  p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sample));
endmodule

bind rx_err_hold rx_err_hold_chk #(.W(W), .NERR(NERR)) u_chk (.*);

// File: tb/tb_rx_err_hold.sv
module tb_rx_err_hold;
  localparam int W = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, status_rd = 1'b0;
  logic [W-1:0] in_sample = '0;
  logic [6:0] err_flags = '0, err_mask = '0;
  logic [1:0] policy = '0;
  logic out_valid, rx_err;
  logic [W-1:0] out_sample;
  logic [6:0] err_status;

  int checks = 0, failures = 0;
  logic e_ov = 0, e_rx = 0;
  logic [W-1:0] e_os = '0, e_held = '0;
  logic [6:0] e_st = '0;

  always #4 clk = ~clk;

  rx_err_hold #(.W(W), .NERR(7)) dut (.*);

  function automatic logic [W-1:0] model_pick(logic hitm, logic [1:0] p,
                                               logic [W-1:0] s, logic [W-1:0] h);
    if (!hitm) return s;
    case (p)
      2'b01:   return '0;
      2'b10:   return s;
      default: return h;
    endcase
  endfunction

  task automatic chk(string tag);
    checks++;
    if (out_valid !== e_ov || rx_err !== e_rx || out_sample !== e_os || err_status !== e_st) begin
      failures++;
      $display("FAIL %s: got v=%0b rx=%0b s=%h st=%b exp v=%0b rx=%0b s=%h st=%b",
               tag, out_valid, rx_err, out_sample, err_status, e_ov, e_rx, e_os, e_st);
    end
  endtask

  task automatic step(string tag, logic v, logic [W-1:0] s, logic [6:0] f,
                      logic [6:0] m, logic [1:0] p, logic rd);
    logic hitm;
    @(negedge clk);
    in_valid = v; in_sample = s; err_flags = f; err_mask = m; policy = p; status_rd = rd;
    hitm = v && ((f & m) != 0);
    e_ov = v; e_rx = hitm;
    if (v) e_os = model_pick(hitm, p, s, e_held);
    if (v && !hitm) e_held = s;
    e_st = (rd ? 7'd0 : e_st) | (v ? f : 7'd0);
    @(negedge clk);
    in_valid = 0; status_rd = 0;
    chk(tag);
    e_ov = 0; e_rx = 0;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    chk("R10 reset state");
    rst_n = 1'b1;
    step("R10 hold after reset is zero", 1, 24'h111111, 7'h01, 7'h7f, 2'b00, 0);
    step("R9 read clears", 0, 0, 0, 0, 0, 1);
    step("R2 clean pass", 1, 24'hA5A5A5, 7'h00, 7'h7f, 2'b00, 0);
    step("R3 hold last good", 1, 24'h123456, 7'h02, 7'h7f, 2'b00, 0);
    step("R3 reserved code holds", 1, 24'h654321, 7'h04, 7'h7f, 2'b11, 0);
    step("R4 zero policy", 1, 24'hFFFFFF, 7'h08, 7'h7f, 2'b01, 0);
    step("R5 pass policy", 1, 24'hBEEF01, 7'h10, 7'h7f, 2'b10, 0);
    step("R11 passed error not held", 1, 24'h777777, 7'h20, 7'h7f, 2'b00, 1);
    step("R6 masked error passes", 1, 24'h0C0C0C, 7'h40, 7'h3f, 2'b01, 0);
    step("R8 sticky status", 0, 24'h999999, 7'h00, 7'h7f, 2'b00, 0);
    step("R9 read with new flag", 1, 24'h0D0D0D, 7'h08, 7'h00, 2'b00, 1);
    step("R12 flags ignored when idle", 0, 24'h555555, 7'h7f, 7'h7f, 2'b01, 0);
    step("R7 event on enabled error", 1, 24'h246810, 7'h01, 7'h01, 2'b10, 0);
    step("R1 idle keeps sample", 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] f, m;
      f = ($urandom % 3 == 0) ? 7'(1 << ($urandom % 7)) : 7'($urandom);
      if ($urandom % 2 == 0) f = '0;
      m = 7'($urandom);
      step("R1/R2/R3/R4/R5/R6/R8/R9 random", ($urandom % 4) != 0, W'($urandom), f, m,
           2'($urandom), ($urandom % 5) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule